// File: doc/BRIEF.md
# Keyed Multi-Channel Watchdog

This block is a watchdog timer with a word-addressed register port. Once started, a down-counter runs from a programmable reload value. Up to eight independent software agents each own a feed channel. A channel is counted only when its enable bit is set. The counter is restored only after every enabled channel has written a fixed 32-bit key to its own feed address within the current period. If the counter reaches zero, a timeout event is latched. A few clocks later, a one-cycle reset request is issued to the system reset logic.

The watchdog can be stopped only when two conditions hold together: a configuration bit permits it, and a separate unlock register holds the same key. A successful stop latches a stopped event. The two events, timeout and stopped, each feed a maskable interrupt and a non-maskable interrupt, and each has its own set and clear enable registers. Two configuration bits decide whether counting continues while the processor reports sleep or halt. While the watchdog runs, its reload value and channel enables are locked.

Top module: `wdt_multichan`

## Requirements
- R1: After reset the run status reads 0, the reload value register reads 0x100, the channel enable register reads 0x01, the request status reads 0, both events read 0, and irq, nmi and reset_req are low.
- R2: A write with bit 0 set to address 0x00 while stopped does three things on that edge. It sets run status (address 0x08, bit 0). It loads the counter (readable at 0x0E) from the reload value (0x0A). It makes the request status (0x09) equal to the channel enable mask (0x0B).
- R3: While counting is allowed, the counter drops by one per clock. On the edge where it would go from 1 to 0, it reads 0 and the timeout event (0x02, bit 0) sets. It then stays at 0 until reset.
- R4: Writing the key 0x6E524635 to address 0x10+n clears request status bit n only while the watchdog runs and channel n is enabled. Any other data, or a disabled channel, leaves the status unchanged.
- R5: A feed that leaves no enabled channel pending causes two things on the same edge. The counter is reloaded from the reload value, and every enabled request status bit is set again.
- R6: reset_req is high for exactly one clock, starting 4 clocks (parameter GRACE) after the edge that set the timeout event.
- R7: A write with bit 0 set to 0x01 has an effect only when config bit 2 (address 0x0C) is set and the unlock register (0x0D) was last written with the key. The effect is to clear run status, freeze the counter and set the stopped event (0x03, bit 0). Otherwise the write is ignored. The unlock register reads 1 while it holds the key.
- R8: Config bit 0 set lets the counter run while cpu_sleep is high, and config bit 1 does the same for cpu_halt. With the matching bit clear, the counter holds while that input is high.
- R9: Enable masks use bit 0 for timeout and bit 1 for stopped. Writing 1 bits to 0x04 sets irq enables and to 0x05 clears them. Addresses 0x06 and 0x07 do the same for nmi enables. Both addresses of a pair read back that pair's mask. irq is the OR of events masked by the irq enables, and nmi is the OR of events masked by the nmi enables.
- R10: Writing 0 to an event address clears that event. Writing any nonzero value there leaves it unchanged.
- R11: While running, writes to the reload value (0x0A) and the channel enable register (0x0B) are ignored. While stopped, they take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one write per clock |
| bus_addr | input | 5 | Word address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cpu_sleep | input | 1 | Processor is sleeping |
| cpu_halt | input | 1 | Processor is halted by a debugger |
| irq | output | 1 | Maskable interrupt request |
| nmi | output | 1 | Non-maskable interrupt request |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The feed logic is tried with four kinds of write:
- a wrong key to an enabled channel;
- the correct key to a disabled channel;
- a partial feed;
- the completing feed.

Together these separate key checking, enable masking and the all-fed reload condition. Stop attempts are made with no config bit, with the config bit but a cleared unlock register, and with both. Each ignored case is seen through run status and the stopped event. Counting is run under sleep and halt with each config bit clear and then set, which shows that each pause is gated by its own bit. A behavioural model in the bench follows every register and output on every clock and is compared with the design each cycle.

// File: rtl/wdt_mc_pkg.sv
`timescale 1ns/10ps
package wdt_mc_pkg;
  localparam int          ADDR_W   = 5;
  localparam logic [31:0] FEED_KEY = 32'h6E52_4635;

  // register word addresses
  localparam int A_START   = 0;
  localparam int A_STOP    = 1;
  localparam int A_EVT_TO  = 2;
  localparam int A_EVT_ST  = 3;
  localparam int A_IE_SET  = 4;
  localparam int A_IE_CLR  = 5;
  localparam int A_NE_SET  = 6;
  localparam int A_NE_CLR  = 7;
  localparam int A_RUN     = 8;
  localparam int A_REQ     = 9;
  localparam int A_RELOAD  = 10;
  localparam int A_CHEN    = 11;
  localparam int A_CFG     = 12;
  localparam int A_UNLOCK  = 13;
  localparam int A_COUNT   = 14;
  localparam int A_FEED0   = 16;

  // event indices
  localparam int EV_TIMEOUT = 0;
  localparam int EV_STOPPED = 1;
  localparam int NUM_EV     = 2;

  // configuration bits
  localparam int CFG_RUN_SLEEP = 0;
  localparam int CFG_RUN_HALT  = 1;
  localparam int CFG_STOP_OK   = 2;
  localparam int CFG_W         = 3;

  // true when, after removing the channels fed this cycle, no enabled one is left
  function automatic logic all_fed(input logic [31:0] pend, input logic [31:0] hit,
                                   input logic [31:0] en);
    return ((pend & ~hit & en) == 32'd0);
  endfunction

  // counting is allowed in this cycle
  function automatic logic may_tick(input logic running, input logic expired,
                                    input logic sleeping, input logic halted,
                                    input logic run_sleep, input logic run_halt);
    return running && !expired && (!sleeping || run_sleep) && (!halted || run_halt);
  endfunction
endpackage

// File: rtl/wdt_mc_feed.sv
`timescale 1ns/10ps
module wdt_mc_feed
  import wdt_mc_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              arm,
  input  logic [NUM_CH-1:0] feed_sel,
  input  logic [NUM_CH-1:0] chan_en,
  output logic [NUM_CH-1:0] pending,
  output logic              reload
);
  logic [NUM_CH-1:0] hit;

  assign hit    = feed_sel & chan_en & {NUM_CH{active}};
  assign reload = (|hit) && all_fed(32'(pending), 32'(hit), 32'(chan_en));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pending[i] <= 1'b1;
      else if (arm || reload)  pending[i] <= 1'b1;
      else if (hit[i])         pending[i] <= 1'b0;
    end
  end

  AST_RELOAD_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (&pending)); // R5
  AST_FEED_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !arm) |=> $stable(pending)); // R4
endmodule

// File: rtl/wdt_mc_countdown.sv
`timescale 1ns/10ps
module wdt_mc_countdown #(
  parameter int CNT_W = 32,
  parameter int GRACE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             expired,
  output logic             expire_now,
  output logic             reset_req
);
  localparam int GW = $clog2(GRACE + 1);

  logic [CNT_W-1:0] count_q;
  logic             expired_q;
  logic [GW-1:0]    grace_q;
  logic             rr_q;

  assign expire_now = tick && !load && !expired_q && (count_q <= CNT_W'(1));
  assign count      = count_q;
  assign expired    = expired_q;
  assign reset_req  = rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      expired_q <= 1'b0;
    end else if (load) begin
      count_q   <= load_val;
    end else if (expire_now) begin
      count_q   <= '0;
      expired_q <= 1'b1;
    end else if (tick && !expired_q) begin
      count_q   <= count_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grace_q <= '0;
      rr_q    <= 1'b0;
    end else begin
      rr_q <= (grace_q == GW'(1));
      if (expire_now)              grace_q <= GW'(GRACE);
      else if (grace_q != GW'(0))  grace_q <= grace_q - GW'(1);
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !expired_q && count_q > CNT_W'(1)) |=> (count_q == $past(count_q) - CNT_W'(1))); // R3
  AST_HOLD_WHEN_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count_q)); // R8
  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req); // R6
  AST_RESET_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> expired_q); // R6
endmodule

// File: rtl/wdt_mc_events.sv
`timescale 1ns/10ps
module wdt_mc_events #(
  parameter int NUM_EV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_set,
  input  logic [NUM_EV-1:0] ev_clr,
  input  logic [NUM_EV-1:0] ie_set,
  input  logic [NUM_EV-1:0] ie_clr,
  input  logic [NUM_EV-1:0] ne_set,
  input  logic [NUM_EV-1:0] ne_clr,
  output logic [NUM_EV-1:0] ev_q,
  output logic [NUM_EV-1:0] ie_q,
  output logic [NUM_EV-1:0] ne_q,
  output logic              irq,
  output logic              nmi
);
  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ev_q[i] <= 1'b0;
        ie_q[i] <= 1'b0;
        ne_q[i] <= 1'b0;
      end else begin
        if (ev_set[i])      ev_q[i] <= 1'b1;
        else if (ev_clr[i]) ev_q[i] <= 1'b0;
        if (ie_set[i])      ie_q[i] <= 1'b1;
        else if (ie_clr[i]) ie_q[i] <= 1'b0;
        if (ne_set[i])      ne_q[i] <= 1'b1;
        else if (ne_clr[i]) ne_q[i] <= 1'b0;
      end
    end

    AST_EVT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_q[i] && !ev_clr[i]) |=> ev_q[i]); // R10
  end

  assign irq = |(ev_q & ie_q);
  assign nmi = |(ev_q & ne_q);

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|ie_q)); // R9
endmodule

// File: rtl/wdt_multichan.sv
`timescale 1ns/10ps
module wdt_multichan
  import wdt_mc_pkg::*;
#(
  parameter int          NUM_CH     = 8,
  parameter int          CNT_W      = 32,
  parameter int          GRACE      = 4,
  parameter logic [31:0] RELOAD_RST = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              cpu_sleep,
  input  logic              cpu_halt,
  output logic              irq,
  output logic              nmi,
  output logic              reset_req
);
  logic              run_q;
  logic [CNT_W-1:0]  rv_q;
  logic [NUM_CH-1:0] en_q;
  logic [CFG_W-1:0]  cfg_q;
  logic              key_ok_q;

  logic              start_fire, stop_fire, active, tick, load, reload;
  logic              expired, expire_now;
  logic [CNT_W-1:0]  count;
  logic [NUM_CH-1:0] feed_sel, pending;
  logic [NUM_EV-1:0] ev_set, ev_clr, ie_set, ie_clr, ne_set, ne_clr, ev_q, ie_q, ne_q;

  // write decodes
  logic w_start, w_stop, w_evto, w_evst, w_ies, w_iec, w_nes, w_nec;
  logic w_reload, w_chen, w_cfg, w_unlock;
  assign w_start  = bus_we && (bus_addr == ADDR_W'(A_START));
  assign w_stop   = bus_we && (bus_addr == ADDR_W'(A_STOP));
  assign w_evto   = bus_we && (bus_addr == ADDR_W'(A_EVT_TO));
  assign w_evst   = bus_we && (bus_addr == ADDR_W'(A_EVT_ST));
  assign w_ies    = bus_we && (bus_addr == ADDR_W'(A_IE_SET));
  assign w_iec    = bus_we && (bus_addr == ADDR_W'(A_IE_CLR));
  assign w_nes    = bus_we && (bus_addr == ADDR_W'(A_NE_SET));
  assign w_nec    = bus_we && (bus_addr == ADDR_W'(A_NE_CLR));
  assign w_reload = bus_we && (bus_addr == ADDR_W'(A_RELOAD));
  assign w_chen   = bus_we && (bus_addr == ADDR_W'(A_CHEN));
  assign w_cfg    = bus_we && (bus_addr == ADDR_W'(A_CFG));
  assign w_unlock = bus_we && (bus_addr == ADDR_W'(A_UNLOCK));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_feed
    assign feed_sel[i] = bus_we && (bus_addr == ADDR_W'(A_FEED0 + i)) && (bus_wdata == FEED_KEY);
  end

  // control events
  assign active     = run_q && !expired;
  assign start_fire = w_start && bus_wdata[0] && !run_q;
  assign stop_fire  = w_stop && bus_wdata[0] && active && cfg_q[CFG_STOP_OK] && key_ok_q;
  assign tick       = may_tick(run_q, expired, cpu_sleep, cpu_halt,
                               cfg_q[CFG_RUN_SLEEP], cfg_q[CFG_RUN_HALT]) && !stop_fire;
  assign load       = start_fire || reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      rv_q     <= CNT_W'(RELOAD_RST);
      en_q     <= NUM_CH'(1);
      cfg_q    <= '0;
      key_ok_q <= 1'b0;
    end else begin
      if (start_fire)          run_q <= 1'b1;
      else if (stop_fire)      run_q <= 1'b0;
      if (w_reload && !run_q)  rv_q  <= bus_wdata[CNT_W-1:0];
      if (w_chen && !run_q)    en_q  <= bus_wdata[NUM_CH-1:0];
      if (w_cfg)               cfg_q <= bus_wdata[CFG_W-1:0];
      if (w_unlock)            key_ok_q <= (bus_wdata == FEED_KEY);
    end
  end

  wdt_mc_feed #(.NUM_CH(NUM_CH)) u_feed (
    .clk(clk), .rst_n(rst_n), .active(active), .arm(start_fire),
    .feed_sel(feed_sel), .chan_en(en_q), .pending(pending), .reload(reload)
  );

  wdt_mc_countdown #(.CNT_W(CNT_W), .GRACE(GRACE)) u_count (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(rv_q), .tick(tick),
    .count(count), .expired(expired), .expire_now(expire_now), .reset_req(reset_req)
  );

  // event and enable strobes
  always_comb begin
    ev_set = '0;
    ev_set[EV_TIMEOUT] = expire_now;
    ev_set[EV_STOPPED] = stop_fire;
    ev_clr = '0;
    ev_clr[EV_TIMEOUT] = w_evto && (bus_wdata == 32'd0);
    ev_clr[EV_STOPPED] = w_evst && (bus_wdata == 32'd0);
    ie_set = w_ies ? bus_wdata[NUM_EV-1:0] : '0;
    ie_clr = w_iec ? bus_wdata[NUM_EV-1:0] : '0;
    ne_set = w_nes ? bus_wdata[NUM_EV-1:0] : '0;
    ne_clr = w_nec ? bus_wdata[NUM_EV-1:0] : '0;
  end

  wdt_mc_events #(.NUM_EV(NUM_EV)) u_events (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .ev_clr(ev_clr),
    .ie_set(ie_set), .ie_clr(ie_clr), .ne_set(ne_set), .ne_clr(ne_clr),
    .ev_q(ev_q), .ie_q(ie_q), .ne_q(ne_q), .irq(irq), .nmi(nmi)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (int'(bus_addr))
      A_EVT_TO:           bus_rdata = 32'(ev_q[EV_TIMEOUT]);
      A_EVT_ST:           bus_rdata = 32'(ev_q[EV_STOPPED]);
      A_IE_SET, A_IE_CLR: bus_rdata = 32'(ie_q);
      A_NE_SET, A_NE_CLR: bus_rdata = 32'(ne_q);
      A_RUN:              bus_rdata = 32'(run_q);
      A_REQ:              bus_rdata = run_q ? 32'(pending & en_q) : 32'd0;
      A_RELOAD:           bus_rdata = 32'(rv_q);
      A_CHEN:             bus_rdata = 32'(en_q);
      A_CFG:              bus_rdata = 32'(cfg_q);
      A_UNLOCK:           bus_rdata = 32'(key_ok_q);
      A_COUNT:            bus_rdata = 32'(count);
      default:            bus_rdata = '0;
    endcase
  end

  AST_RELOAD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(rv_q)); // R11
  AST_CHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(en_q)); // R11
  AST_STOP_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> $past(cfg_q[CFG_STOP_OK] && key_ok_q)); // R7
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (count == $past(rv_q))); // R2
endmodule

// File: tb/wdt_multichan_test.sv
`timescale 1ns/10ps
module wdt_multichan_test;
  localparam int          NCH    = 8;
  localparam int          GR     = 4;
  localparam logic [31:0] KEY    = 32'h6E524635;
  localparam logic [31:0] RST_RV = 32'h100;
  localparam logic [4:0] R_START = 0, R_STOP = 1, R_EVTO = 2, R_EVST = 3, R_IES = 4, R_IEC = 5,
                         R_NES = 6, R_NEC = 7, R_RUN = 8, R_REQ = 9, R_RV = 10, R_CHEN = 11,
                         R_CFG = 12, R_KEY = 13, R_CNT = 14, R_FEED = 16;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, cpu_sleep = 1'b0, cpu_halt = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, nmi, reset_req;

  always #2 clk = ~clk;

  wdt_multichan uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_sleep(cpu_sleep), .cpu_halt(cpu_halt),
    .irq(irq), .nmi(nmi), .reset_req(reset_req)
  );

  int checks = 0, fails = 0, cyc = 0;

  // behavioural reference model
  bit          m_run = 0, m_exp = 0, m_key = 0, m_rr = 0;
  int unsigned m_cnt = 0, m_rv = RST_RV, m_grace = 0;
  bit [7:0]    m_pend = 8'hFF, m_en = 8'h01;
  bit [2:0]    m_cfg = 0;
  bit [1:0]    m_ev = 0, m_ie = 0, m_ne = 0;
  bit          t_tick, t_fed, t_stop;
  int          t_ch;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_exp = 0; m_key = 0; m_rr = 0; m_cnt = 0; m_rv = RST_RV; m_grace = 0;
      m_pend = 8'hFF; m_en = 8'h01; m_cfg = 0; m_ev = 0; m_ie = 0; m_ne = 0;
    end else begin
      m_rr = (m_grace == 1);
      if (m_grace != 0) m_grace--;
      t_tick = m_run && !m_exp && (!cpu_sleep || m_cfg[0]) && (!cpu_halt || m_cfg[1]);
      t_stop = bus_we && bus_addr == R_STOP && bus_wdata[0] && m_run && !m_exp && m_cfg[2] && m_key;
      t_fed  = 0;
      t_ch   = int'(bus_addr) - int'(R_FEED);
      if (bus_we && t_ch >= 0 && t_ch < NCH && bus_wdata == KEY && m_run && !m_exp && m_en[t_ch]) begin
        m_pend[t_ch] = 0;
        if ((m_pend & m_en) == 0) t_fed = 1;
      end
      if (bus_we && bus_addr == R_EVTO && bus_wdata == 0) m_ev[0] = 0;
      if (bus_we && bus_addr == R_EVST && bus_wdata == 0) m_ev[1] = 0;
      if (t_stop) begin
        m_run = 0; m_ev[1] = 1;
      end else if (t_fed) begin
        m_cnt = m_rv; m_pend = 8'hFF;
      end else if (t_tick) begin
        if (m_cnt <= 1) begin m_cnt = 0; m_exp = 1; m_ev[0] = 1; m_grace = GR; end
        else m_cnt--;
      end
      if (bus_we && bus_addr == R_START && bus_wdata[0] && !m_run && !t_stop) begin
        m_run = 1; m_cnt = m_rv; m_pend = 8'hFF;
      end
      if (bus_we) begin
        case (bus_addr)
          R_IES: m_ie = m_ie | bus_wdata[1:0];
          R_IEC: m_ie = m_ie & ~bus_wdata[1:0];
          R_NES: m_ne = m_ne | bus_wdata[1:0];
          R_NEC: m_ne = m_ne & ~bus_wdata[1:0];
          R_RV:   if (!m_run) m_rv = bus_wdata;
          R_CHEN: if (!m_run) m_en = bus_wdata[7:0];
          R_CFG:  m_cfg = bus_wdata[2:0];
          R_KEY:  m_key = (bus_wdata == KEY);
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      R_EVTO:       return {31'b0, m_ev[0]};
      R_EVST:       return {31'b0, m_ev[1]};
      R_IES, R_IEC: return {30'b0, m_ie};
      R_NES, R_NEC: return {30'b0, m_ne};
      R_RUN:        return {31'b0, m_run};
      R_REQ:        return m_run ? {24'b0, m_pend & m_en} : 32'd0;
      R_RV:         return m_rv;
      R_CHEN:       return {24'b0, m_en};
      R_CFG:        return {29'b0, m_cfg};
      R_KEY:        return {31'b0, m_key};
      R_CNT:        return m_cnt;
      default:      return 32'd0;
    endcase
  endfunction

  // lockstep compare, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      checks++;
      if (bus_rdata !== m_read(bus_addr) || irq !== |(m_ev & m_ie) || nmi !== |(m_ev & m_ne)
          || reset_req !== m_rr) begin
        fails++;
        $display("FAIL R3 lockstep addr=%0d actual rd=%h irq=%b nmi=%b rr=%b expected rd=%h irq=%b nmi=%b rr=%b",
                 bus_addr, bus_rdata, irq, nmi, reset_req, m_read(bus_addr),
                 |(m_ev & m_ie), |(m_ev & m_ne), m_rr);
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d cycles expected<=5000", cyc);
      summary();
      $finish;
    end
  end

  task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #0.1;
    expect32(tag, bus_rdata, exp);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(R_RUN, 0, "R1 run");
    rd(R_RV, RST_RV, "R1 reload");
    rd(R_CHEN, 1, "R1 chen");
    rd(R_REQ, 0, "R1 req");
    rd(R_EVTO, 0, "R1 evto");
    expect32("R1 outs", {29'b0, irq, nmi, reset_req}, 0);

    wr(R_RV, 10);
    wr(R_CHEN, 8'h05);
    rd(R_RV, 10, "R11 reload unlocked");
    rd(R_CHEN, 5, "R11 chen unlocked");

    wr(R_START, 1);                           // S: count 10
    rd(R_RUN, 1, "R2 run");
    rd(R_REQ, 5, "R2 req");
    rd(R_CNT, 10, "R2 count");
    wr(R_RV, 99);                             // 9
    wr(R_CHEN, 8'hFF);                        // 8
    rd(R_RV, 10, "R11 reload locked");
    rd(R_CHEN, 5, "R11 chen locked");
    rd(R_CNT, 8, "R3 count");

    wr(R_FEED + 0, 32'h12345678);             // 7
    rd(R_REQ, 5, "R4 wrong key");
    wr(R_FEED + 1, KEY);                      // 6
    rd(R_REQ, 5, "R4 disabled channel");
    wr(R_FEED + 0, KEY);                      // 5
    rd(R_REQ, 4, "R4 feed ch0");
    rd(R_CNT, 5, "R4 count");
    wr(R_FEED + 2, KEY);                      // reload 10
    rd(R_REQ, 5, "R5 rearm");
    rd(R_CNT, 10, "R5 reload");

    wr(R_STOP, 1);                            // 9
    rd(R_RUN, 1, "R7 no cfg no key");
    rd(R_EVST, 0, "R7 no event");
    wr(R_KEY, KEY);                           // 8
    wr(R_STOP, 1);                            // 7
    rd(R_RUN, 1, "R7 key without cfg");
    wr(R_CFG, 4);                             // 6
    wr(R_KEY, 0);                             // 5
    rd(R_KEY, 0, "R7 unlock cleared");
    wr(R_STOP, 1);                            // 4
    rd(R_RUN, 1, "R7 cfg without key");
    wr(R_KEY, KEY);                           // 3
    wr(R_FEED + 0, KEY);                      // 2
    wr(R_FEED + 2, KEY);                      // 10
    rd(R_CNT, 10, "R5 reload again");
    wr(R_STOP, 1);
    rd(R_RUN, 0, "R7 stopped");
    rd(R_EVST, 1, "R7 stopped event");
    rd(R_CNT, 10, "R7 frozen");

    expect32("R9 irq masked", {31'b0, irq}, 0);
    wr(R_IES, 2);
    expect32("R9 irq enabled", {31'b0, irq}, 1);
    wr(R_NES, 2);
    expect32("R9 nmi enabled", {31'b0, nmi}, 1);
    wr(R_IEC, 2);
    expect32("R9 irq cleared", {30'b0, irq, nmi}, 32'h1);
    rd(R_IES, 0, "R9 ie mask");

    wr(R_EVST, 5);
    rd(R_EVST, 1, "R10 nonzero ignored");
    wr(R_EVST, 0);
    rd(R_EVST, 0, "R10 cleared");
    expect32("R10 nmi drops", {31'b0, nmi}, 0);

    wr(R_RV, 6);
    rd(R_RV, 6, "R11 reload after stop");

    cpu_sleep = 1'b1;
    wr(R_START, 1);                           // count 6
    idle(3);
    rd(R_CNT, 6, "R8 sleep pauses");
    cpu_sleep = 1'b0; cpu_halt = 1'b1;
    idle(2);
    rd(R_CNT, 6, "R8 halt pauses");
    wr(R_CFG, 6);
    rd(R_CNT, 6, "R8 cfg edge");
    idle(1);
    rd(R_CNT, 5, "R8 runs in halt");
    cpu_halt = 1'b0; cpu_sleep = 1'b1;
    idle(1);
    rd(R_CNT, 5, "R8 sleep still pauses");
    cpu_sleep = 1'b0;
    idle(4);
    rd(R_CNT, 1, "R3 count one");
    rd(R_EVTO, 0, "R3 no timeout yet");
    idle(1);
    rd(R_CNT, 0, "R3 count zero");
    rd(R_EVTO, 1, "R3 timeout");
    expect32("R9 nmi masked timeout", {31'b0, nmi}, 0);
    idle(3);
    expect32("R6 grace", {31'b0, reset_req}, 0);
    idle(1);
    expect32("R6 pulse", {31'b0, reset_req}, 1);
    idle(1);
    expect32("R6 one cycle", {31'b0, reset_req}, 0);
    wr(R_NES, 1);
    expect32("R9 nmi timeout", {31'b0, nmi}, 1);
    idle(2);
    summary();
    $finish;
  end
endmodule